// File: doc/BRIEF.md
# Interrupt Source Event-State Controller

This block keeps a bank of interrupt sources. Each source holds a two-bit state made of a pending flag P and a queued flag Q. Hardware trigger lines change the state, and so does an address-decoded load/store port. A trigger that finds a source idle moves it to pending and raises a one-cycle notify strobe. The strobe carries the source number to a downstream router. While the source is pending, further triggers only set Q. A source therefore sits in the downstream queue at most once until software ends it with an end-of-interrupt (EOI).

Each source owns a page in the address space at `source << PAGE_SHIFT`. With a two-page layout, the lower half of each page is for triggering and the upper half is for management. With a single-page layout, one page does both jobs. Management loads are decoded from bits [11:8] of the address. Every management load returns the source's previous state and changes it in the same cycle. Level-sensitive sources, chosen by a parameter mask, also keep a line-asserted bit. When that line is still high at EOI, the source is re-triggered.

Top module: `irq_event_state`

## Requirements
- R1: After reset every source state is 00 and no read result or notify is presented. A query of any source returns 000.
- R2: A trigger on a source in state 00 (idle) moves it to 10 (pending: P is bit 1, Q is bit 0). It also makes one notify carrying that source number.
- R3: A trigger on a source in state 10 moves it to 11, and a trigger in state 11 leaves it at 11. Neither makes a notify. A notify is only presented for a source whose P bit is set.
- R4: State 01 (off) ignores triggers: the state stays 01 and no notify follows.
- R5: A load at management offset 0x800 returns {line-asserted, P, Q} in rdData[2:0]. The source state does not change.
- R6: A load at management offset 0x000 is an EOI and returns the old state. If Q was 0 the state becomes 00. If Q was 1 it becomes 10 and a new notify is made.
- R7: Loads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 return the old state and force PQ to address bits [9:8] (00, 01, 10, 11). They make no notify.
- R8: A store at management offset 0x400 is an EOI (same transitions as R6, no read result) when STORE_EOI_EN is 1. It has no effect when STORE_EOI_EN is 0.
- R9: The page of source s starts at s << PAGE_SHIFT. For PAGE_SHIFT 13 or 17, address bit PAGE_SHIFT-1 selects the management half (1) or the trigger half (0). Any store to the trigger half triggers, stores to other management offsets are ignored, and loads to the trigger half only return the state. For PAGE_SHIFT 12 or 16, any store except at offset 0x400 triggers.
- R10: For a source set in LEVEL_MASK, a rising edge of its input triggers, and a held level does not trigger again. Bit 2 of a query reports the line. An EOI while the line is still high re-triggers to 10 with a notify.
- R11: Notifies made in the same cycle are presented one per cycle, lowest source number first. A notify appears in the cycle after the clock edge that sampled its cause.
- R12: rdValid and rdData appear in the cycle after the clock edge that took the load. rdValid is 0 in cycles with no load.
- R13: When a bus operation and a hardware trigger hit the same source in one cycle, the bus operation is applied first and the trigger is applied to its result. The read returns the state from before both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | NUM_SRC | Hardware trigger lines: a pulse per event for edge sources, a level for level sources |
| busValid | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = store, 0 = load |
| busAddr | input | SRC_W+PAGE_SHIFT | Byte address: source number above PAGE_SHIFT, offset below |
| rdValid | output | 1 | Load result valid |
| rdData | output | 3 | Previous {line-asserted, P, Q} of the loaded source |
| notifyValid | output | 1 | Notify strobe toward the router |
| notifySrc | output | SRC_W | Source number carried by the notify |

## Verification
The hardest cases to reach from the ports need two things in the same clock cycle. One is a bus operation and a hardware trigger on one source at once. Another is several sources firing together, so they compete for the notify output. A third is an EOI landing while a level line is still held. The bench drives the trigger lines in the same cycle as a bus request, and it pulses several lines together. It holds a level input high across an EOI and then drops it one idle cycle before the next query. It also runs a second single-page instance with store-EOI turned off, so both layouts and both settings of the store-EOI flag are reached.

// File: rtl/irqst_pkg.sv
package irqst_pkg;

  localparam logic [1:0] PQ_IDLE   = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  // strobes from the address decoder to the state datapath
  typedef struct packed {
    logic       doRead;
    logic       doEoi;
    logic       doSet;
    logic       doTrig;
    logic [1:0] setVal;
  } opStrobe_t;

endpackage

// File: rtl/irqst_decode.sv
module irqst_decode
  import irqst_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int PAGE_SHIFT   = 16,
  parameter bit STORE_EOI_EN = 1'b1,
  parameter int SRC_W        = 3,
  parameter int ADDR_W       = 19
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output opStrobe_t         opStb,
  output logic [SRC_W-1:0]  opSrc
);

  localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

  logic       inRange;
  logic       mgmtHalf;
  logic       trigHalf;
  logic [3:0] off;
  logic       stEoiSlot;
  logic       unusedAddr;

  assign opSrc      = busAddr[ADDR_W-1:PAGE_SHIFT];
  assign off        = busAddr[11:8];
  assign stEoiSlot  = (off[3:2] == 2'b01);
  assign unusedAddr = ^busAddr;

  generate
    if ((1 << SRC_W) == NUM_SRC) begin : g_full
      assign inRange = 1'b1;
    end else begin : g_part
      assign inRange = (opSrc < SRC_W'(NUM_SRC));
    end
    if (TWO_PAGE) begin : g_two
      assign mgmtHalf = busAddr[PAGE_SHIFT-1];
      assign trigHalf = ~busAddr[PAGE_SHIFT-1];
    end else begin : g_one
      assign mgmtHalf = 1'b1;
      assign trigHalf = 1'b1;
    end
  endgenerate

  always_comb begin
    opStb = '0;
    if (busValid && inRange) begin
      if (!busWrite) begin
        opStb.doRead = 1'b1;
        if (mgmtHalf) begin
          opStb.doEoi  = (off[3:2] == 2'b00);
          opStb.doSet  = (off[3:2] == 2'b11);
          opStb.setVal = off[1:0];
        end
      end else if (mgmtHalf && stEoiSlot) begin
        opStb.doEoi = STORE_EOI_EN;
      end else if (trigHalf) begin
        opStb.doTrig = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqst_state.sv
module irqst_state
  import irqst_pkg::*;
#(
  parameter int                 NUM_SRC    = 8,
  parameter int                 SRC_W      = 3,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  opStrobe_t          opStb,
  input  logic [SRC_W-1:0]   opSrc,
  output logic               rdValid,
  output logic [2:0]         rdData,
  output logic               notifyValid,
  output logic [SRC_W-1:0]   notifySrc
);

  logic [1:0]         pq     [NUM_SRC];
  logic [1:0]         nxtPq  [NUM_SRC];
  logic [NUM_SRC-1:0] lineQ;
  logic [NUM_SRC-1:0] reqQ;
  logic [NUM_SRC-1:0] nxtReq;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] hwTrig;
  logic [NUM_SRC-1:0] grant;
  logic [SRC_W-1:0]   pick;
  logic               anyReq;

  // fixed priority: lowest pending source number goes first
  always_comb begin
    pick   = '0;
    anyReq = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqQ[i]) begin
        pick   = SRC_W'(i);
        anyReq = 1'b1;
      end
    end
    grant = anyReq ? (NUM_SRC'(1) << pick) : '0;
  end

  // bus operation first, then trigger on its result
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      logic [1:0] n;
      logic       fire;
      hit[i]    = (opSrc == SRC_W'(i));
      hwTrig[i] = LEVEL_MASK[i] ? (trigIn[i] & ~lineQ[i]) : trigIn[i];
      n    = pq[i];
      fire = 1'b0;
      if (hit[i] && opStb.doSet) n = opStb.setVal;
      if (hit[i] && opStb.doEoi) begin
        if (pq[i][0] || (LEVEL_MASK[i] && lineQ[i])) begin
          n    = PQ_PEND;
          fire = 1'b1;
        end else begin
          n = PQ_IDLE;
        end
      end
      if (hwTrig[i] || (hit[i] && opStb.doTrig)) begin
        case (n)
          PQ_IDLE: begin
            n    = PQ_PEND;
            fire = 1'b1;
          end
          PQ_PEND: n = PQ_QUEUED;
          default: n = n;
        endcase
      end
      nxtPq[i]  = n;
      nxtReq[i] = fire | (reqQ[i] & ~grant[i] & n[1] & ~(hit[i] & opStb.doSet));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) pq[i] <= PQ_IDLE;
      lineQ   <= '0;
      reqQ    <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) pq[i] <= nxtPq[i];
      lineQ   <= trigIn & LEVEL_MASK;
      reqQ    <= nxtReq;
      rdValid <= opStb.doRead;
      if (opStb.doRead) rdData <= {lineQ[opSrc], pq[opSrc]};
    end
  end

  assign notifyValid = anyReq;
  assign notifySrc   = pick;

  // R3: a source is only announced while its P bit holds
  p_notify_holds_p_r3: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> pq[notifySrc][1]);

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
      p_query_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
        (hit[g] && opStb.doRead && !opStb.doEoi && !opStb.doSet && !hwTrig[g])
        |=> (pq[g] == $past(pq[g])));
      p_set_forces_r7: assert property (@(posedge clk) disable iff (!rstN)
        (hit[g] && opStb.doSet && !hwTrig[g]) |=> (pq[g] == $past(opStb.setVal)));
      p_off_sticks_r4: assert property (@(posedge clk) disable iff (!rstN)
        (pq[g] == PQ_OFF && !(hit[g] && (opStb.doSet || opStb.doEoi)))
        |=> (pq[g] == PQ_OFF));
      p_eoi_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
        (hit[g] && opStb.doEoi && !pq[g][0] && !(LEVEL_MASK[g] && lineQ[g]) && !hwTrig[g])
        |=> (pq[g] == PQ_IDLE));
    end
  endgenerate

endmodule

// File: rtl/irq_event_state.sv
module irq_event_state
  import irqst_pkg::*;
#(
  parameter int                 NUM_SRC      = 8,
  parameter int                 PAGE_SHIFT   = 16,
  parameter bit                 STORE_EOI_EN = 1'b1,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK   = '0,
  localparam int                SRC_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int                ADDR_W       = SRC_W + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  output logic               rdValid,
  output logic [2:0]         rdData,
  output logic               notifyValid,
  output logic [SRC_W-1:0]   notifySrc
);

  opStrobe_t        opStb;
  logic [SRC_W-1:0] opSrc;

  irqst_decode #(
    .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT), .STORE_EOI_EN(STORE_EOI_EN),
    .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .opStb(opStb), .opSrc(opSrc)
  );

  irqst_state #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .LEVEL_MASK(LEVEL_MASK)
  ) u_state (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .opStb(opStb), .opSrc(opSrc),
    .rdValid(rdValid), .rdData(rdData),
    .notifyValid(notifyValid), .notifySrc(notifySrc)
  );

endmodule

// File: tb/sim_irq_event_state.sv
module sim_irq_event_state;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  // u0: 8 sources, two-page layout, store EOI on, source 7 level-sensitive
  logic [7:0]  trig0 = '0;
  logic        bv0 = 1'b0, bw0 = 1'b0;
  logic [15:0] ba0 = '0;
  logic        rv0, nv0;
  logic [2:0]  rd0, ns0;

  irq_event_state #(.NUM_SRC(8), .PAGE_SHIFT(13), .STORE_EOI_EN(1'b1), .LEVEL_MASK(8'h80)) u0 (
    .clk(clk), .rstN(rstN), .trigIn(trig0), .busValid(bv0), .busWrite(bw0), .busAddr(ba0),
    .rdValid(rv0), .rdData(rd0), .notifyValid(nv0), .notifySrc(ns0));

  // u1: 4 sources, single-page layout, store EOI off
  logic        bv1 = 1'b0, bw1 = 1'b0;
  logic [13:0] ba1 = '0;
  logic        rv1, nv1;
  logic [2:0]  rd1;
  logic [1:0]  ns1;

  irq_event_state #(.NUM_SRC(4), .PAGE_SHIFT(12), .STORE_EOI_EN(1'b0), .LEVEL_MASK(4'h0)) u1 (
    .clk(clk), .rstN(rstN), .trigIn(4'h0), .busValid(bv1), .busWrite(bw1), .busAddr(ba1),
    .rdValid(rv1), .rdData(rd1), .notifyValid(nv1), .notifySrc(ns1));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input int req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmpOut(input int req, input logic erv, input logic [2:0] erd, input logic env,
                        input int ens, input logic rv, input logic [2:0] rd, input logic nv, input int ns);
    chk(rv == erv, req, "rdValid", rv, erv);
    if (erv) chk(rd == erd, req, "rdData", rd, erd);
    chk(nv == env, req, "notifyValid", nv, env);
    if (env) chk(ns == ens, req, "notifySrc", ns, ens);
  endtask

  // one bus cycle on u0, optional same-cycle trigger lines; check after the edge
  task automatic op0(input logic wr, input logic mg, input logic [2:0] src, input logic [3:0] off,
                     input logic [7:0] tg, input logic erv, input logic [2:0] erd,
                     input logic env, input logic [2:0] ens, input int req);
    bv0 = 1'b1; bw0 = wr; ba0 = {src, mg, off, 8'h00}; trig0 = tg;
    @(posedge clk); @(negedge clk);
    bv0 = 1'b0; trig0 = '0;
    cmpOut(req, erv, erd, env, int'(ens), rv0, rd0, nv0, int'(ns0));
  endtask

  task automatic op1(input logic wr, input logic [1:0] src, input logic [3:0] off,
                     input logic erv, input logic [2:0] erd, input logic env, input logic [1:0] ens,
                     input int req);
    bv1 = 1'b1; bw1 = wr; ba1 = {src, off, 8'h00};
    @(posedge clk); @(negedge clk);
    bv1 = 1'b0;
    cmpOut(req, erv, erd, env, int'(ens), rv1, rd1, nv1, int'(ns1));
  endtask

  typedef struct packed {
    logic       wr;
    logic       mg;
    logic [2:0] src;
    logic [3:0] off;
    logic       rv;
    logic [2:0] rd;
    logic       nv;
    logic [2:0] ns;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b1,3'd2,4'h8,1'b1,3'b000,1'b0,3'd0,4'd5},  // R5 query idle
    '{1'b1,1'b0,3'd2,4'h0,1'b0,3'b000,1'b1,3'd2,4'd2},  // R2 trigger from idle
    '{1'b1,1'b0,3'd2,4'h0,1'b0,3'b000,1'b0,3'd0,4'd3},  // R3 trigger while pending
    '{1'b0,1'b1,3'd2,4'h8,1'b1,3'b011,1'b0,3'd0,4'd3},  // R3 now queued
    '{1'b0,1'b1,3'd2,4'h0,1'b1,3'b011,1'b1,3'd2,4'd6},  // R6 EOI with Q
    '{1'b0,1'b1,3'd2,4'h8,1'b1,3'b010,1'b0,3'd0,4'd6},  // R6
    '{1'b0,1'b1,3'd2,4'h0,1'b1,3'b010,1'b0,3'd0,4'd6},  // R6 EOI without Q
    '{1'b0,1'b1,3'd2,4'h8,1'b1,3'b000,1'b0,3'd0,4'd6},  // R6
    '{1'b0,1'b1,3'd2,4'hD,1'b1,3'b000,1'b0,3'd0,4'd7},  // R7 force off
    '{1'b1,1'b0,3'd2,4'h0,1'b0,3'b000,1'b0,3'd0,4'd4},  // R4 trigger ignored
    '{1'b0,1'b1,3'd2,4'h8,1'b1,3'b001,1'b0,3'd0,4'd4},  // R4
    '{1'b0,1'b1,3'd2,4'hF,1'b1,3'b001,1'b0,3'd0,4'd7},  // R7 force queued
    '{1'b1,1'b1,3'd2,4'h4,1'b0,3'b000,1'b1,3'd2,4'd8},  // R8 store EOI
    '{1'b0,1'b1,3'd2,4'h8,1'b1,3'b010,1'b0,3'd0,4'd8},  // R8
    '{1'b1,1'b1,3'd2,4'h8,1'b0,3'b000,1'b0,3'd0,4'd9},  // R9 other mgmt store
    '{1'b0,1'b1,3'd2,4'h8,1'b1,3'b010,1'b0,3'd0,4'd9},  // R9
    '{1'b0,1'b0,3'd2,4'h0,1'b1,3'b010,1'b0,3'd0,4'd9},  // R9 load on trigger half
    '{1'b0,1'b1,3'd2,4'hC,1'b1,3'b010,1'b0,3'd0,4'd7},  // R7 force idle
    '{1'b1,1'b0,3'd5,4'h0,1'b0,3'b000,1'b1,3'd5,4'd9},  // R9 page of source 5
    '{1'b0,1'b1,3'd2,4'h8,1'b1,3'b000,1'b0,3'd0,4'd9},  // R9 neighbour untouched
    '{1'b0,1'b1,3'd5,4'h8,1'b1,3'b010,1'b0,3'd0,4'd9},  // R9
    '{1'b0,1'b1,3'd5,4'hC,1'b1,3'b010,1'b0,3'd0,4'd7},  // R7
    '{1'b0,1'b1,3'd4,4'hE,1'b1,3'b000,1'b0,3'd0,4'd7},  // R7 force pending, no notify
    '{1'b0,1'b1,3'd4,4'h8,1'b1,3'b010,1'b0,3'd0,4'd7},  // R7
    '{1'b0,1'b1,3'd4,4'hC,1'b1,3'b010,1'b0,3'd0,4'd12}  // R12 read one cycle later
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(rv0 == 1'b0, 1, "rdValid after reset", rv0, 0);
    chk(nv0 == 1'b0, 1, "notifyValid after reset", nv0, 0);
    for (int s = 0; s < 8; s++) op0(1'b0, 1'b1, 3'(s), 4'h8, 8'h00, 1'b1, 3'b000, 1'b0, 3'd0, 1);

    for (int k = 0; k < NVEC; k++)
      op0(VEC[k].wr, VEC[k].mg, VEC[k].src, VEC[k].off, 8'h00,
          VEC[k].rv, VEC[k].rd, VEC[k].nv, VEC[k].ns, int'(VEC[k].req));

    // R12 no read result in an idle cycle
    @(posedge clk); @(negedge clk);
    chk(rv0 == 1'b0, 12, "rdValid idle", rv0, 0);

    // R11 three simultaneous triggers, lowest first
    trig0 = 8'b0001_0110;
    @(posedge clk); @(negedge clk);
    trig0 = '0;
    chk(nv0 && ns0 == 3'd1, 11, "first notify", int'(ns0), 1);
    @(posedge clk); @(negedge clk);
    chk(nv0 && ns0 == 3'd2, 11, "second notify", int'(ns0), 2);
    @(posedge clk); @(negedge clk);
    chk(nv0 && ns0 == 3'd4, 11, "third notify", int'(ns0), 4);
    @(posedge clk); @(negedge clk);
    chk(nv0 == 1'b0, 11, "notify drained", nv0, 0);
    op0(1'b0, 1'b1, 3'd1, 4'hC, 8'h00, 1'b1, 3'b010, 1'b0, 3'd0, 11);
    op0(1'b0, 1'b1, 3'd2, 4'hC, 8'h00, 1'b1, 3'b010, 1'b0, 3'd0, 11);
    op0(1'b0, 1'b1, 3'd4, 4'hC, 8'h00, 1'b1, 3'b010, 1'b0, 3'd0, 11);

    // R13 force-idle and hardware trigger on source 3 in one cycle
    op0(1'b0, 1'b1, 3'd3, 4'hC, 8'h08, 1'b1, 3'b000, 1'b1, 3'd3, 13);
    op0(1'b0, 1'b1, 3'd3, 4'h8, 8'h00, 1'b1, 3'b010, 1'b0, 3'd0, 13);
    op0(1'b0, 1'b1, 3'd3, 4'hC, 8'h00, 1'b1, 3'b010, 1'b0, 3'd0, 13);

    // R10 level source 7
    trig0 = 8'h80;
    @(posedge clk); @(negedge clk);
    chk(nv0 && ns0 == 3'd7, 10, "level rising notify", int'(ns0), 7);
    op0(1'b0, 1'b1, 3'd7, 4'h8, 8'h80, 1'b1, 3'b110, 1'b0, 3'd0, 10);
    trig0 = 8'h80;
    op0(1'b0, 1'b1, 3'd7, 4'h0, 8'h80, 1'b1, 3'b110, 1'b1, 3'd7, 10);
    op0(1'b0, 1'b1, 3'd7, 4'h8, 8'h80, 1'b1, 3'b110, 1'b0, 3'd0, 10);
    trig0 = '0;
    @(posedge clk); @(negedge clk);
    op0(1'b0, 1'b1, 3'd7, 4'h8, 8'h00, 1'b1, 3'b010, 1'b0, 3'd0, 10);
    op0(1'b0, 1'b1, 3'd7, 4'h0, 8'h00, 1'b1, 3'b010, 1'b0, 3'd0, 10);
    op0(1'b0, 1'b1, 3'd7, 4'h8, 8'h00, 1'b1, 3'b000, 1'b0, 3'd0, 10);

    // u1: single page, store EOI disabled (R8, R9)
    op1(1'b1, 2'd1, 4'h0, 1'b0, 3'b000, 1'b1, 2'd1, 9);
    op1(1'b1, 2'd1, 4'h4, 1'b0, 3'b000, 1'b0, 2'd0, 8);
    op1(1'b0, 2'd1, 4'h8, 1'b1, 3'b010, 1'b0, 2'd0, 8);
    op1(1'b1, 2'd1, 4'h8, 1'b0, 3'b000, 1'b0, 2'd0, 9);
    op1(1'b0, 2'd1, 4'h8, 1'b1, 3'b011, 1'b0, 2'd0, 9);
    op1(1'b0, 2'd1, 4'h0, 1'b1, 3'b011, 1'b1, 2'd1, 6);
    op1(1'b0, 2'd1, 4'hC, 1'b1, 3'b010, 1'b0, 2'd0, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule